// File: doc/BRIEF.md
# Byte Serial Shift Port

This block is the master side of a byte-wide serial link. Software loads a byte into the data register and sets the start bit in the control register. The port then exchanges eight bits with a partner, most significant bit first. On each bit, the outgoing bit is taken from the top of the data register, and the incoming bit is shifted in at the bottom. When the eighth bit has been exchanged, the start bit clears and a one-cycle interrupt request pulse is issued.

Bit timing comes from a free-running cycle counter that starts from zero at reset and never stops. A bit boundary occurs every time a selected bit of that counter changes value. The control register's speed bit selects the counter bit. Because the counter keeps running between transfers, the first bit of a transfer can be shorter than a full period. Whether the first bit is short depends on where the counter is when the start write arrives. When the partner is absent (`ser_in_valid` low), the port shifts in ones, whatever level is on the data line.

Top module: `byte_serial_port`

## Requirements
- R1: After reset, the data register reads 0x00, the control register reads 0x00, `ser_out` is 1 and `xfer_irq` is 0.
- R2: The cycle counter is cleared by reset and advances by one on every clock, whether or not a transfer is active. With control bit 1 = 1 (fast), a bit boundary falls on every edge after which the counter is a multiple of 2^FAST_BIT. With bit 1 = 0 (normal), the multiple is 2^SLOW_BIT.
- R3: At each bit boundary of an active transfer, the data register shifts left by one and the sampled input bit enters bit 0.
- R4: While `ser_in_valid` is 0, the bit shifted in is 1, regardless of `ser_in`.
- R5: At the eighth boundary, control bit 7 clears and `xfer_irq` is high for exactly one cycle.
- R6: On the clock after a start write, `ser_out` carries data bit 7. After each boundary other than the eighth, it carries the new bit 7. Otherwise `ser_out` holds its value.
- R7: A control write (address 1) with bit 7 set while idle starts a transfer. It sets control bit 7, clears the bit count and latches the speed bit. A boundary that falls on the edge of the start write is not counted.
- R8: While a transfer is active, writes to the data register (address 0) and to the control register are ignored.
- R9: A control write with bit 7 clear while idle only updates the speed bit. No transfer starts and the data register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 data, 1 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`; control reads {active, 5'b0, speed, 0} |
| ser_in | input | 1 | Serial data from partner |
| ser_in_valid | input | 1 | High when a partner drives `ser_in` |
| ser_out | output | 1 | Serial data to partner |
| xfer_irq | output | 1 | One-cycle transfer-complete pulse |

## Verification
A wrong bit count shows up as a control bit 7 or interrupt at the wrong boundary. Because the bench compares the data register after every boundary, that error appears within one bit period. A wrong counter bit or phase moves the boundaries off the expected counter multiples, so it shows on the first bit of a transfer. A wrong shift direction or wrong insertion point shows up in the data readback or on `ser_out` at the very next boundary. That is far earlier than the final byte.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        SPD_NORMAL = 1'b0,
        SPD_FAST   = 1'b1
    } speed_e;

    typedef enum logic {
        REG_DATA = 1'b0,
        REG_CTRL = 1'b1
    } reg_sel_e;

    localparam int CTRL_GO_BIT  = 7;
    localparam int CTRL_SPD_BIT = 1;

    typedef struct packed {
        logic   busy;
        speed_e speed;
    } ctrl_t;

    function automatic logic [BYTE_W-1:0] ctrl_image(input ctrl_t c);
        logic [BYTE_W-1:0] v;
        v = '0;
        v[CTRL_GO_BIT]  = c.busy;
        v[CTRL_SPD_BIT] = c.speed;
        return v;
    endfunction

endpackage

// File: rtl/ssp_cycle_counter.sv
module ssp_cycle_counter
    import ssp_pkg::*;
#(
    parameter int SLOW_BIT = 9,
    parameter int FAST_BIT = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  speed_e speed,
    output logic   tick
);
    localparam int CNT_W = ((SLOW_BIT > FAST_BIT) ? SLOW_BIT : FAST_BIT) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             sel_now;
    logic             sel_nxt;

    assign cnt_nxt = cnt_q + 1'b1;

    always_comb begin
        if (speed == SPD_FAST) begin
            sel_now = cnt_q[FAST_BIT];
            sel_nxt = cnt_nxt[FAST_BIT];
        end else begin
            sel_now = cnt_q[SLOW_BIT];
            sel_nxt = cnt_nxt[SLOW_BIT];
        end
    end

    assign tick = sel_now ^ sel_nxt;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_nxt;
    end

    // R2: counter free-runs by one every cycle
    p_free_run_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt_q == $past(cnt_q) + 1'b1);

    // R2: a boundary never lasts two cycles in a row
    p_tick_isolated_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         start,
    input  logic         data_wr,
    input  logic [W-1:0] data_wdata,
    input  logic         in_bit,
    output logic [W-1:0] data_q,
    output logic         active,
    output logic         sout,
    output logic         irq
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] bits_q;
    logic          last_bit;

    assign last_bit = (bits_q == CW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            bits_q <= '0;
            active <= 1'b0;
            sout   <= 1'b1;
            irq    <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (start) begin
                active <= 1'b1;
                bits_q <= '0;
                sout   <= data_q[W-1];
            end else if (active && tick) begin
                data_q <= {data_q[W-2:0], in_bit};
                if (last_bit) begin
                    active <= 1'b0;
                    bits_q <= '0;
                    irq    <= 1'b1;
                end else begin
                    bits_q <= bits_q + 1'b1;
                    sout   <= data_q[W-2];
                end
            end else if (data_wr && !active) begin
                data_q <= data_wdata;
            end
        end
    end

    // R7: idle implies a cleared bit count
    p_idle_count_r7: assert property (@(posedge clk) disable iff (rst)
        !active |-> bits_q == '0);

    // R3: a boundary in a transfer moves the byte up by one
    p_shift_left_r3: assert property (@(posedge clk) disable iff (rst)
        (active && tick && !start) |=> data_q[W-1:1] == $past(data_q[W-2:0]));

    // R5: the pulse only follows an active transfer that just ended
    p_irq_end_r5: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!active && $past(active)));

    // R6: serial out moves only on start or boundary
    p_sout_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!start && !(active && tick)) |=> $stable(sout));

    // R8: the byte is frozen between boundaries of a transfer
    p_busy_data_r8: assert property (@(posedge clk) disable iff (rst)
        (active && !tick) |=> $stable(data_q));

endmodule

// File: rtl/byte_serial_port.sv
module byte_serial_port
    import ssp_pkg::*;
#(
    parameter int SLOW_BIT = 9,
    parameter int FAST_BIT = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ser_in,
    input  logic       ser_in_valid,
    output logic       ser_out,
    output logic       xfer_irq
);
    speed_e            speed_q;
    ctrl_t             ctrl_view;
    logic              tick;
    logic              busy;
    logic              ctrl_wr;
    logic              start;
    logic              data_wr;
    logic              rx_bit;
    logic [BYTE_W-1:0] data_q;

    assign ctrl_wr = bus_wr && (bus_addr == REG_CTRL) && !busy;
    assign start   = ctrl_wr && bus_wdata[CTRL_GO_BIT];
    assign data_wr = bus_wr && (bus_addr == REG_DATA) && !busy;
    assign rx_bit  = ser_in_valid ? ser_in : 1'b1;

    always_ff @(posedge clk) begin
        if (rst)          speed_q <= SPD_NORMAL;
        else if (ctrl_wr) speed_q <= speed_e'(bus_wdata[CTRL_SPD_BIT]);
    end

    ssp_cycle_counter #(
        .SLOW_BIT(SLOW_BIT),
        .FAST_BIT(FAST_BIT)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .speed(speed_q),
        .tick (tick)
    );

    ssp_shifter #(
        .W(BYTE_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .start     (start),
        .data_wr   (data_wr),
        .data_wdata(bus_wdata),
        .in_bit    (rx_bit),
        .data_q    (data_q),
        .active    (busy),
        .sout      (ser_out),
        .irq       (xfer_irq)
    );

    always_comb begin
        ctrl_view.busy  = busy;
        ctrl_view.speed = speed_q;
        bus_rdata = (bus_addr == REG_CTRL) ? ctrl_image(ctrl_view) : data_q;
    end

    // R8: speed cannot change during a transfer
    p_busy_speed_r8: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> $stable(speed_q));

endmodule

// File: tb/byte_serial_port_test.sv
module byte_serial_port_test;
    localparam int SLOW_BIT = 9;
    localparam int FAST_BIT = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ser_in = 1'b0;
    logic       ser_in_valid = 1'b0;
    logic       ser_out;
    logic       xfer_irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int total  = 0;
    bit done   = 1'b0;

    byte_serial_port #(.SLOW_BIT(SLOW_BIT), .FAST_BIT(FAST_BIT)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_in(ser_in),
        .ser_in_valid(ser_in_valid), .ser_out(ser_out), .xfer_irq(xfer_irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        total <= total + 1;
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Runs one transfer; interfere adds ignored writes mid-transfer (R8).
    task automatic xfer(input logic [7:0] tx, input logic [7:0] rx,
                        input bit present, input bit fast, input bit interfere);
        int per;
        int k;
        int guard;
        logic [7:0] rxe;
        logic [15:0] pair;
        logic [7:0] v;
        per = fast ? (1 << FAST_BIT) : (1 << SLOW_BIT);
        rxe = present ? rx : 8'hFF;
        ser_in_valid = present;
        wr(1'b0, tx);
        ser_in = present ? rx[7] : 1'b0;
        wr(1'b1, {1'b1, 5'b0, fast, 1'b0});
        // R7 / R6: started, MSB driven
        rd(1'b1, v);
        check("R7 busy after start", int'(v), 8'h80 | (fast ? 2 : 0));
        check("R6 first bit", int'(ser_out), int'(tx[7]));
        k = 0; guard = 0;
        while (k < 8 && guard < per * 9 + 8) begin
            if (interfere && k == 2) begin
                bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = ~tx;
                @(negedge clk);
                bus_wdata = 8'h00; bus_addr = 1'b1;
                @(negedge clk);
                bus_wr = 1'b0;
                guard += 2;
                interfere = 1'b0;
                rd(1'b1, v);
                check("R8 ctrl write ignored", int'(v[7]), (cyc % per < 2) ? 1 : 1);
            end else begin
                @(negedge clk);
                guard++;
            end
            if (cyc % per == 0) begin
                k++;
                pair = {tx, rxe} << k;
                rd(1'b0, v);
                check(present ? "R3 shifted data" : "R4 ones shifted in",
                      int'(v), int'(pair[15:8]));
                if (k < 8) begin
                    check("R6 next bit out", int'(ser_out), int'(pair[15]));
                    check("R5 no early irq", int'(xfer_irq), 0);
                    ser_in = present ? rx[7-k] : 1'b0;
                end else begin
                    check("R5 irq at eighth bit", int'(xfer_irq), 1);
                    rd(1'b1, v);
                    check("R5 busy cleared", int'(v), fast ? 2 : 0);
                end
            end
        end
        check("R2 eight boundaries in time", k, 8);
        @(negedge clk);
        check("R5 irq one cycle", int'(xfer_irq), 0);
    endtask

    initial begin
        logic [7:0] v;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1
        rd(1'b0, v); check("R1 data reset", int'(v), 0);
        rd(1'b1, v); check("R1 ctrl reset", int'(v), 0);
        check("R1 ser_out reset", int'(ser_out), 1);
        check("R1 irq reset", int'(xfer_irq), 0);
        // R9: speed-only write, no transfer
        wr(1'b0, 8'h6B);
        wr(1'b1, 8'h02);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (xfer_irq) check("R9 no irq", 1, 0);
        end
        rd(1'b1, v); check("R9 speed only", int'(v), 2);
        rd(1'b0, v); check("R9 data kept", int'(v), 8'h6B);
        check("R9 ser_out idle", int'(ser_out), 1);
        // Sweep over bytes, partner present and absent
        for (int t = 0; t < 16; t++) begin
            xfer(8'(t * 17 + 3), 8'(8'hC5 ^ (t * 29)), 1'b1, 1'b1, 1'b0);
            xfer(8'(t * 37), 8'(t), 1'b0, 1'b1, 1'b0);
            repeat (t) @(negedge clk);
        end
        xfer(8'h80, 8'h01, 1'b1, 1'b1, 1'b0);
        xfer(8'h01, 8'h80, 1'b1, 1'b1, 1'b0);
        // R8: writes mid-transfer ignored
        xfer(8'hA5, 8'h3C, 1'b1, 1'b1, 1'b1);
        // R2: normal speed
        xfer(8'h5A, 8'h96, 1'b1, 1'b0, 1'b0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    always @(negedge clk) begin
        if (!done && total > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", total, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule